// File: doc/BRIEF.md
# Error-Feedback Noise Shaping Requantizer

This block shortens each oversampled audio sample from a wide signed word to a narrow signed word that a pulse-width stage can turn into pulses no shorter than the power switches can follow. Dropping the low bits adds quantization noise. The block keeps the dropped part of each sample, filters the most recent dropped parts through a fixed fifth-order FIR, and adds the result to the next incoming sample. This pushes the noise energy out of the audio band and toward the carrier region, where the output LC filter removes it.

A sample is taken on every cycle that the input strobe is high. The narrow word appears one cycle later with its own strobe. Cycles without a strobe leave both the error history and the output word untouched, so the sample rate can be any divisor of the clock. The corrected sum is clamped to the input range before the split, so the output word never wraps and the stored error never grows beyond one output step.

Top module: `nshape_requant`

## Requirements
- R1: `word_vld` is high in exactly the cycles that follow a cycle with `smp_vld` high, and low in all other cycles after reset.
- R2: The output word is the upper OUT_W bits of the clamped corrected sum, which is rounding toward minus infinity by a step of 2^(IN_W-OUT_W). Both the input and the output word are two's complement.
- R3: The corrected sum is the input sample plus floor(S/8), where S = 12·e1 − 8·e2 + 4·e3 − 2·e4 + 1·e5 and ek is the error stored k accepted samples earlier. Before any sample has been accepted, every ek is zero.
- R4: The corrected sum is clamped to the signed IN_W-bit range [−2^(IN_W−1), 2^(IN_W−1)−1]. A positive overload gives output +2^(OUT_W−1)−1 and stored error 2^(IN_W−OUT_W)−1. A negative overload gives output −2^(OUT_W−1) and stored error 0.
- R5: The stored error for a sample is the low IN_W−OUT_W bits of the clamped sum, read as an unsigned value. The error history moves by one place only on a strobed cycle, so idle cycles between samples do not change any later output.
- R6: Reset (synchronous, active high) clears the error history, the output word and `word_vld`. After reset, a zero input gives a zero output.
- R7: The output word keeps its value in every cycle that follows a cycle with no input strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Input sample strobe |
| smp_in | input | IN_W | Oversampled input sample, signed |
| word_vld | output | 1 | Output word strobe, one cycle after `smp_vld` |
| word_out | output | OUT_W | Requantized output word, signed |

## Verification
The hardest state to reach is an overload where the clamp acts while the error history is full of large stored fractions. Only then do the clamp value, the stored error and the next sample's feedback all depend on each other. The stimulus reaches this state with long runs of full-scale positive and negative samples, placed between constrained-random stretches that have irregular gaps in the strobe. A reset issued in the middle of a stream, followed by a zero sample, shows whether the history has been cleared.

// File: rtl/nsq_pkg.sv
`timescale 1ns/1ps
package nsq_pkg;
   // coefficient word width and binary point of the feedback taps
   localparam int COEF_W  = 6;
   localparam int COEF_SH = 3;
   localparam int MAX_ORD = 5;

   // tap k weights the error stored k accepted samples ago (Q3 fixed point)
   function automatic int nsq_coef(input int k);
      case (k)
         1:       return 12;
         2:       return -8;
         3:       return 4;
         4:       return -2;
         5:       return 1;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/nsq_err_fir.sv
`timescale 1ns/1ps
module nsq_err_fir
   import nsq_pkg::*;
#(
   parameter int ERR_W = 9,
   parameter int ORDER = 5,
   parameter int ACC_W = 19
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    shift_en,
   input  logic [ERR_W-1:0]        err_new,
   output logic signed [ACC_W-1:0] fb
);
   localparam int P_W = ERR_W + 1 + COEF_W;

   logic [ORDER-1:0][ERR_W-1:0] hist;
   logic signed [P_W-1:0]       prod [ORDER];
   logic signed [ACC_W-1:0]     acc;

   always_ff @(posedge clk) begin
      if (rst) begin
         hist <= '0;
      end else if (shift_en) begin
         for (int k = ORDER - 1; k > 0; k--) hist[k] <= hist[k-1];
         hist[0] <= err_new;
      end
   end

   for (genvar k = 0; k < ORDER; k++) begin : g_tap
      localparam logic signed [COEF_W-1:0] CV = COEF_W'(nsq_coef(k + 1));
      assign prod[k] = P_W'($signed({1'b0, hist[k]})) * P_W'(CV);
   end

   always_comb begin
      acc = '0;
      for (int k = 0; k < ORDER; k++) acc = acc + ACC_W'(prod[k]);
   end

   assign fb = acc >>> COEF_SH;

   // R5: history frozen on idle cycles
   p_hist_idle_r5: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(hist));
   // R6: reset empties the history
   p_hist_clear_r6: assert property (@(posedge clk)
      rst |=> (hist == '0));
endmodule

// File: rtl/nsq_sat_quant.sv
`timescale 1ns/1ps
module nsq_sat_quant #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 7,
   parameter int V_W   = 20
) (
   input  logic signed [V_W-1:0]    v_sum,
   output logic [OUT_W-1:0]         q_word,
   output logic [IN_W-OUT_W-1:0]    q_err,
   output logic                     ovf_hi,
   output logic                     ovf_lo
);
   localparam int D = IN_W - OUT_W;
   localparam logic signed [V_W-1:0] HI = V_W'((64'sd1 <<< (IN_W - 1)) - 64'sd1);
   localparam logic signed [V_W-1:0] LO = -HI - V_W'(1);

   logic [IN_W-1:0] v_sat;

   assign ovf_hi = (v_sum > HI);
   assign ovf_lo = (v_sum < LO);

   always_comb begin
      if (ovf_hi)      v_sat = HI[IN_W-1:0];
      else if (ovf_lo) v_sat = LO[IN_W-1:0];
      else             v_sat = v_sum[IN_W-1:0];
   end

   assign q_word = v_sat[IN_W-1:D];
   assign q_err  = v_sat[D-1:0];
endmodule

// File: rtl/nshape_requant.sv
`timescale 1ns/1ps
module nshape_requant
   import nsq_pkg::*;
#(
   parameter int IN_W  = 16,
   parameter int OUT_W = 7,
   parameter int ORDER = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             smp_vld,
   input  logic [IN_W-1:0]  smp_in,
   output logic             word_vld,
   output logic [OUT_W-1:0] word_out
);
   localparam int D     = IN_W - OUT_W;
   localparam int ACC_W = D + 1 + COEF_W + $clog2(ORDER + 1);
   localparam int V_W   = ((IN_W > ACC_W) ? IN_W : ACC_W) + 1;
   localparam logic [OUT_W-1:0] W_MAX = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] W_MIN = {1'b1, {(OUT_W-1){1'b0}}};

   if (OUT_W < 4 || OUT_W > 8) begin : g_bad_out
      $error("nshape_requant: OUT_W must lie in 4..8");
   end
   if (ORDER < 1 || ORDER > MAX_ORD) begin : g_bad_ord
      $error("nshape_requant: ORDER must lie in 1..MAX_ORD");
   end
   if (IN_W <= OUT_W + 1) begin : g_bad_in
      $error("nshape_requant: IN_W must exceed OUT_W by at least two");
   end

   logic signed [ACC_W-1:0] fb;
   logic signed [V_W-1:0]   v_sum;
   logic [OUT_W-1:0]        q_word;
   logic [D-1:0]            q_err;
   logic                    ovf_hi, ovf_lo;

   nsq_err_fir #(.ERR_W(D), .ORDER(ORDER), .ACC_W(ACC_W)) fir_i (
      .clk(clk), .rst(rst), .shift_en(smp_vld), .err_new(q_err), .fb(fb)
   );

   assign v_sum = $signed({{(V_W-IN_W){smp_in[IN_W-1]}}, smp_in})
                + $signed({{(V_W-ACC_W){fb[ACC_W-1]}}, fb});

   nsq_sat_quant #(.IN_W(IN_W), .OUT_W(OUT_W), .V_W(V_W)) quant_i (
      .v_sum(v_sum), .q_word(q_word), .q_err(q_err),
      .ovf_hi(ovf_hi), .ovf_lo(ovf_lo)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         word_vld <= 1'b0;
         word_out <= '0;
      end else begin
         word_vld <= smp_vld;
         if (smp_vld) word_out <= q_word;
      end
   end

   // R1: strobe follows strobe by one cycle
   p_vld_follow_r1: assert property (@(posedge clk) disable iff (rst)
      smp_vld |=> word_vld);
   p_vld_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      !smp_vld |=> !word_vld);
   // R7: word holds on idle cycles
   p_word_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !smp_vld |=> $stable(word_out));
   // R4: overloads land on the range ends
   p_sat_hi_r4: assert property (@(posedge clk) disable iff (rst)
      (smp_vld && ovf_hi) |=> (word_out == W_MAX));
   p_sat_lo_r4: assert property (@(posedge clk) disable iff (rst)
      (smp_vld && ovf_lo) |=> (word_out == W_MIN));
endmodule

// File: tb/nshape_requant_tb_top.sv
`timescale 1ns/1ps
module nshape_requant_tb_top;
   localparam int IN_W  = 16;
   localparam int OUT_W = 7;
   localparam int D     = IN_W - OUT_W;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             smp_vld = 1'b0;
   logic [IN_W-1:0]  smp_in = '0;
   logic             word_vld;
   logic [OUT_W-1:0] word_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   int eh [1:5];
   int held = 0;

   always #2.5 clk = ~clk;

   nshape_requant #(.IN_W(IN_W), .OUT_W(OUT_W), .ORDER(5)) dut_i (
      .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_in(smp_in),
      .word_vld(word_vld), .word_out(word_out)
   );

   function automatic int tap(input int k);
      case (k) 1: return 12; 2: return -8; 3: return 4; 4: return -2; default: return 1; endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int k = 1; k <= 5; k++) eh[k] = 0;
      held = 0;
   endtask

   // R3/R4/R5 reference: compute the expected word and update the history
   function automatic int model_step(input int x);
      int s, v, q, e;
      s = 0;
      for (int k = 1; k <= 5; k++) s += tap(k) * eh[k];
      v = x + (s >>> 3);
      if (v > 32767) v = 32767;
      if (v < -32768) v = -32768;
      q = v >>> D;
      e = v & ((1 << D) - 1);
      for (int k = 5; k > 1; k--) eh[k] = eh[k-1];
      eh[1] = e;
      return q;
   endfunction

   task automatic step(input bit v, input int x, input string req);
      smp_vld = v;
      smp_in  = IN_W'(x);
      if (v) held = model_step(x);
      @(negedge clk);
      chk(word_vld == v, "R1", int'(word_vld), int'(v));
      chk($signed(word_out) == held, req, int'($signed(word_out)), held);
   endtask

   initial begin
      int x;
      void'($urandom(32'd2718));
      model_clear();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(word_vld == 1'b0, "R6", int'(word_vld), 0);
      chk(word_out == '0, "R6", int'(word_out), 0);

      // zero after reset gives zero (R6)
      step(1'b1, 0, "R6");
      // small values, back to back (R2, R3)
      step(1'b1, 511, "R2");
      step(1'b1, 512, "R2");
      step(1'b1, -1, "R2");
      step(1'b1, -513, "R3");
      // idle cycles keep the word (R7) and do not move history (R5)
      step(1'b0, 12345, "R7");
      step(1'b0, -777, "R7");
      step(1'b1, 1000, "R5");

      // full-scale positive run (R4)
      for (int i = 0; i < 40; i++) step(1'b1, 32767, "R4");
      // full-scale negative run (R4)
      for (int i = 0; i < 40; i++) step(1'b1, -32768, "R4");
      // alternating extremes (R4)
      for (int i = 0; i < 20; i++) step(1'b1, (i % 2) ? -32768 : 32767, "R4");

      // constrained random with gaps (R2, R3, R5, R7)
      for (int i = 0; i < 600; i++) begin
         x = int'($signed(16'($urandom)));
         if ($urandom_range(3) == 0) x = x >>> 5;
         if ($urandom_range(4) == 0) step(1'b0, x, "R7");
         else step(1'b1, x, "R3");
      end

      // reset mid-stream clears history (R6)
      for (int i = 0; i < 5; i++) step(1'b1, 30000 - i * 1111, "R3");
      smp_vld = 1'b1;
      smp_in  = 16'h7fff;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      smp_vld = 1'b0;
      model_clear();
      @(negedge clk);
      chk(word_vld == 1'b0, "R6", int'(word_vld), 0);
      chk(word_out == '0, "R6", int'(word_out), 0);
      step(1'b1, 0, "R6");
      step(1'b1, -32768, "R4");
      step(1'b1, 0, "R5");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule